// File: doc/BRIEF.md
# PCI Interrupt Router Matrix

This block steers four shared PCI interrupt request lines (A, B, C, D) onto sixteen legacy interrupt-controller inputs. Each request line has its own byte-wide steering register. A byte below 16 names the controller input that the line drives. Any larger value detaches the line. Several request lines may be steered onto the same input, and that input is then the OR of their levels.

Internally the block keeps a level matrix with one bit per (input, line) pair, at bit index `irq*4 + line`. Every clock this matrix is rebuilt from the live request levels and the current steering bytes. A steering change therefore moves an asserted level from its old input to its new one without leaving a stale bit behind.

The block also answers a combinational per-line route query. A small helper converts a device/function number and an INTx pin into the request line that the pin reaches: line = (intx + slot - 1) mod 4, where slot = devfn >> 3.

Top module: `pirq_router`

## Requirements
- R1: After reset every steering byte holds 0x80, the route query reports every line as detached, and `irq_out` is all zero.
- R2: A write with `wr_addr` equal to 0x60 + n (n = 0..3, n=0 is line A) loads `wr_data` into the steering byte of line n at that clock edge. A write to any other address changes no steering byte.
- R3: A steering byte of 16 or more detaches its line. The line's level then reaches no output, and the query returns `qry_en`=0 with `qry_irq`=4'hF.
- R4: For a steering byte below 16, the query for that line returns `qry_en`=1 and `qry_irq` equal to the byte's value.
- R5: Output bit i is high exactly when at least one attached line steered to input i has its level high. Lines that share an input combine by OR.
- R6: A request-level change sampled at a clock edge appears on `irq_out` right after that edge, and not before it.
- R7: When a line is re-steered, the clock edge that loads the new byte still shows the old routing on `irq_out`. From the following edge on, the line's live level appears only on its new input, and re-steering to a value of 16 or more clears the line's contribution.
- R8: `slot_pirq` equals (`intx_pin` + (`devfn` >> 3) + 3) mod 4, which is the same as (intx + slot - 1) mod 4. The low three bits of `devfn` do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Configuration byte address |
| wr_data | input | 8 | Configuration write byte |
| pirq_lvl | input | 4 | Live levels of request lines A..D (bit 0 = A) |
| irq_out | output | 16 | Level outputs to the interrupt-controller inputs |
| qry_pin | input | 2 | Line whose route is queried |
| qry_en | output | 1 | Queried line is attached |
| qry_irq | output | 4 | Queried line's input number, 4'hF when detached |
| devfn | input | 8 | Device/function number for the slot helper |
| intx_pin | input | 2 | INTx pin index (0 = INTA) |
| slot_pirq | output | 2 | Request line that the pin reaches |

## Verification
A vector table applies steering patterns and checks each one against the expected output word and route-query answers:
- Distinct one-to-one steerings show that each line reaches its own input.
- Steering all lines onto one input shows the OR merge.
- Mixtures that include 0x0F, 0x10, 0x1F, 0x80 and 0xFF show the 15/16 detach boundary.
- Level patterns with gaps catch swapped line indices.

Directed tests cover:
- the latency of one clock for a level change;
- the two-edge sequence when an asserted line is re-steered, which exposes a stale matrix bit;
- writes just outside the steering window;
- a reset in the middle of a run.

Slot-helper cases wrap around zero and the top slot, and include nonzero function bits.

// File: rtl/pirq_rt_pkg.sv
package pirq_rt_pkg;
   // answer state of a route lookup
   typedef enum logic {
      ROUTE_OFF = 1'b0,
      ROUTE_ON  = 1'b1
   } route_state_e;
endpackage

// File: rtl/pirq_rt_steer_regs.sv
// Steering byte storage, one register per request line.
module pirq_rt_steer_regs #(
   parameter int unsigned N_PIRQ    = 4,
   parameter int unsigned RB_W      = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE      = 'h60,
   parameter int unsigned ROUTE_RST = 'h80
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [RB_W-1:0]              wr_data,
   output logic [N_PIRQ-1:0][RB_W-1:0]  route_q
);
   for (genvar p = 0; p < N_PIRQ; p++) begin : g_line
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(BASE + p));   // R2

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   route_q[p] <= RB_W'(ROUTE_RST);          // R1
         else if (hit) route_q[p] <= wr_data;
      end
   end
endmodule

// File: rtl/pirq_rt_level_map.sv
// Line-by-input level matrix, rebuilt every clock from live levels.
module pirq_rt_level_map #(
   parameter int unsigned N_PIRQ = 4,
   parameter int unsigned N_IRQ  = 16,
   parameter int unsigned RB_W   = 8,
   localparam int unsigned IRQ_W = $clog2(N_IRQ),
   localparam int unsigned MAP_W = N_PIRQ * N_IRQ
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_PIRQ-1:0][RB_W-1:0]  route_q,
   input  logic [N_PIRQ-1:0]            pirq_lvl,
   output logic [N_IRQ-1:0]             irq_out
);
   logic [MAP_W-1:0]  map_d;
   logic [MAP_W-1:0]  map_q;
   logic [N_PIRQ-1:0] live;

   for (genvar p = 0; p < N_PIRQ; p++) begin : g_live
      assign live[p] = route_q[p] < RB_W'(N_IRQ);   // R3
   end

   // bit index = irq * N_PIRQ + line
   for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      for (genvar p = 0; p < N_PIRQ; p++) begin : g_line
         assign map_d[i*N_PIRQ + p] = pirq_lvl[p] && live[p] &&
                                      (route_q[p][IRQ_W-1:0] == IRQ_W'(i));
      end
      assign irq_out[i] = |map_q[i*N_PIRQ +: N_PIRQ];   // R5
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_q <= '0;      // R1
      else        map_q <= map_d;   // R6 R7
   end
endmodule

// File: rtl/pirq_rt_slot_map.sv
// Device slot plus INTx pin to request line.
module pirq_rt_slot_map #(
   parameter int unsigned N_PIRQ    = 4,
   parameter int unsigned DEVFN_W   = 8,
   parameter int unsigned FUNC_BITS = 3,
   localparam int unsigned PIRQ_W = $clog2(N_PIRQ),
   localparam int unsigned SLOT_W = DEVFN_W - FUNC_BITS,
   localparam int unsigned SUM_W  = (SLOT_W > PIRQ_W ? SLOT_W : PIRQ_W) + 2
) (
   input  logic [DEVFN_W-1:0] devfn,
   input  logic [PIRQ_W-1:0]  intx_pin,
   output logic [PIRQ_W-1:0]  slot_pirq
);
   logic [SLOT_W-1:0] slot;
   logic [SUM_W-1:0]  sum;
   logic              unused_func;

   assign slot        = devfn[DEVFN_W-1:FUNC_BITS];
   assign unused_func = ^devfn[FUNC_BITS-1:0];
   // adding N_PIRQ-1 is subtracting one modulo N_PIRQ
   assign sum       = SUM_W'(slot) + SUM_W'(intx_pin) + SUM_W'(N_PIRQ - 1);
   assign slot_pirq = sum[PIRQ_W-1:0];   // R8
endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
   parameter int unsigned N_PIRQ    = 4,
   parameter int unsigned N_IRQ     = 16,
   parameter int unsigned RB_W      = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE      = 'h60,
   parameter int unsigned ROUTE_RST = 'h80,
   parameter int unsigned DEVFN_W   = 8,
   parameter int unsigned FUNC_BITS = 3,
   localparam int unsigned PIRQ_W = $clog2(N_PIRQ),
   localparam int unsigned IRQ_W  = $clog2(N_IRQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [RB_W-1:0]    wr_data,
   input  logic [N_PIRQ-1:0]  pirq_lvl,
   output logic [N_IRQ-1:0]   irq_out,
   input  logic [PIRQ_W-1:0]  qry_pin,
   output logic               qry_en,
   output logic [IRQ_W-1:0]   qry_irq,
   input  logic [DEVFN_W-1:0] devfn,
   input  logic [PIRQ_W-1:0]  intx_pin,
   output logic [PIRQ_W-1:0]  slot_pirq
);
   import pirq_rt_pkg::*;

   // elaboration checks on the parameter set
   if ((1 << PIRQ_W) != N_PIRQ) begin : g_chk_pirq
      $error("N_PIRQ must be a power of two");
   end
   if ((1 << IRQ_W) != N_IRQ) begin : g_chk_irq
      $error("N_IRQ must be a power of two");
   end
   if (N_IRQ >= (1 << RB_W)) begin : g_chk_rb
      $error("steering byte too narrow to express a detached value");
   end
   if (BASE + N_PIRQ > (1 << ADDR_W)) begin : g_chk_addr
      $error("steering window exceeds address space");
   end
   if (FUNC_BITS >= DEVFN_W) begin : g_chk_devfn
      $error("devfn has no slot field");
   end

   logic [N_PIRQ-1:0][RB_W-1:0] route_q;
   logic [RB_W-1:0]             qry_byte;
   route_state_e                qry_state;

   pirq_rt_steer_regs #(
      .N_PIRQ(N_PIRQ), .RB_W(RB_W), .ADDR_W(ADDR_W),
      .BASE(BASE), .ROUTE_RST(ROUTE_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .route_q(route_q)
   );

   pirq_rt_level_map #(
      .N_PIRQ(N_PIRQ), .N_IRQ(N_IRQ), .RB_W(RB_W)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .route_q(route_q),
      .pirq_lvl(pirq_lvl), .irq_out(irq_out)
   );

   pirq_rt_slot_map #(
      .N_PIRQ(N_PIRQ), .DEVFN_W(DEVFN_W), .FUNC_BITS(FUNC_BITS)
   ) u_slot (
      .devfn(devfn), .intx_pin(intx_pin), .slot_pirq(slot_pirq)
   );

   // route query, same attach rule as the level matrix (R3 R4)
   assign qry_byte  = route_q[qry_pin];
   assign qry_state = (qry_byte < RB_W'(N_IRQ)) ? ROUTE_ON : ROUTE_OFF;
   assign qry_en    = (qry_state == ROUTE_ON);
   assign qry_irq   = qry_en ? qry_byte[IRQ_W-1:0] : '1;
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
   parameter int unsigned N_PIRQ = 4,
   parameter int unsigned N_IRQ  = 16,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned BASE   = 'h60,
   localparam int unsigned PIRQ_W = $clog2(N_PIRQ),
   localparam int unsigned IRQ_W  = $clog2(N_IRQ)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [N_PIRQ-1:0] pirq_lvl,
   input logic [N_IRQ-1:0]  irq_out,
   input logic [PIRQ_W-1:0] qry_pin,
   input logic              qry_en,
   input logic [IRQ_W-1:0]  qry_irq
);
   logic win_hit;
   assign win_hit = wr_en && (int'(wr_addr) >= int'(BASE)) &&
                    (int'(wr_addr) < int'(BASE + N_PIRQ));

   AST_QUIET_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (pirq_lvl == '0) |=> (irq_out == '0));                               // R5

   AST_OUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(irq_out) <= $countones($past(pirq_lvl)));                // R5

   AST_DETACHED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_en |-> (qry_irq == '1));                                        // R3

   AST_QRY_DRIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(qry_en) && $past(pirq_lvl[qry_pin])) |-> irq_out[$past(qry_irq)]); // R4

   AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !win_hit |=> ($stable(qry_pin) ? ($stable(qry_en) && $stable(qry_irq)) : 1'b1)); // R2
endmodule

bind pirq_router pirq_router_chk #(
   .N_PIRQ(N_PIRQ), .N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .pirq_lvl(pirq_lvl), .irq_out(irq_out), .qry_pin(qry_pin),
   .qry_en(qry_en), .qry_irq(qry_irq)
);

// File: tb/pirq_router_tb.sv
module pirq_router_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] pirq_lvl = '0;
   logic [15:0] irq_out;
   logic [1:0] qry_pin = '0;
   logic       qry_en;
   logic [3:0] qry_irq;
   logic [7:0] devfn = '0;
   logic [1:0] intx_pin = '0;
   logic [1:0] slot_pirq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   pirq_router u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pirq_lvl(pirq_lvl), .irq_out(irq_out),
      .qry_pin(qry_pin), .qry_en(qry_en), .qry_irq(qry_irq),
      .devfn(devfn), .intx_pin(intx_pin), .slot_pirq(slot_pirq)
   );

   // {steering bytes D..A, levels D..A, expected irq_out}
   localparam logic [51:0] VECS [8] = '{
      {32'h06050403, 4'b1111, 16'h0078},
      {32'h06050403, 4'b0101, 16'h0028},
      {32'h0A0A0A0A, 4'b0010, 16'h0400},
      {32'h0A0A0A0A, 4'b0000, 16'h0000},
      {32'h80100F00, 4'b1111, 16'h8001},
      {32'h09FF1F0F, 4'b1111, 16'h8200},
      {32'h02020101, 4'b1001, 16'h0006},
      {32'h08070807, 4'b0110, 16'h0180}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic qry(input string tag, input int pin, input logic [7:0] b);
      logic [4:0] exp;
      exp = (b < 8'd16) ? {1'b1, b[3:0]} : 5'b0_1111;
      qry_pin = pin[1:0];
      #1;
      check(tag, {27'b0, qry_en, qry_irq}, {27'b0, exp});
   endtask

   task automatic slot_chk(input logic [7:0] df, input logic [1:0] ix, input logic [1:0] exp);
      devfn = df; intx_pin = ix;
      #1;
      check("R8 slot map", {30'b0, slot_pirq}, {30'b0, exp});
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset out", {16'b0, irq_out}, 32'h0);
      for (int p = 0; p < 4; p++) qry("R1 reset query", p, 8'h80);
      rst_n = 1'b1;
      // R3 detached lines raise nothing
      @(negedge clk); pirq_lvl = 4'hF;
      @(posedge clk); @(negedge clk);
      check("R3 detached out", {16'b0, irq_out}, 32'h0);

      // table walk: R2 R3 R4 R5
      for (int v = 0; v < 8; v++) begin
         for (int p = 0; p < 4; p++) wr(8'h60 + 8'(p), VECS[v][20 + 8*p +: 8]);
         pirq_lvl = VECS[v][19:16];
         @(posedge clk); @(negedge clk);
         check($sformatf("R5 vec %0d out", v), {16'b0, irq_out}, {16'b0, VECS[v][15:0]});
         for (int p = 0; p < 4; p++)
            qry($sformatf("R4 vec %0d query", v), p, VECS[v][20 + 8*p +: 8]);
      end

      // R2 writes outside the window are ignored
      wr(8'h60, 8'h01); wr(8'h61, 8'h02); wr(8'h62, 8'h03); wr(8'h63, 8'h04);
      wr(8'h5F, 8'h0E); wr(8'h64, 8'h0D); wr(8'hE0, 8'h0C);
      qry("R2 stray A", 0, 8'h01); qry("R2 stray B", 1, 8'h02);
      qry("R2 stray C", 2, 8'h03); qry("R2 stray D", 3, 8'h04);

      // R6 level latency
      wr(8'h61, 8'h80); wr(8'h62, 8'h80); wr(8'h63, 8'h80); wr(8'h60, 8'h05);
      pirq_lvl = 4'b0000;
      @(posedge clk); @(negedge clk);
      pirq_lvl = 4'b0001;
      #1 check("R6 before edge", {16'b0, irq_out}, 32'h0);
      @(posedge clk); @(negedge clk);
      check("R6 after edge", {16'b0, irq_out}, 32'h0020);

      // R7 re-steer an asserted line
      wr(8'h60, 8'h09);
      check("R7 load edge old", {16'b0, irq_out}, 32'h0020);
      @(posedge clk); @(negedge clk);
      check("R7 new input", {16'b0, irq_out}, 32'h0200);
      wr(8'h60, 8'h10);
      @(posedge clk); @(negedge clk);
      check("R7 detach clears", {16'b0, irq_out}, 32'h0);

      // R1 reset in the middle of a run
      wr(8'h60, 8'h03);
      @(posedge clk); @(negedge clk);
      check("R1 pre-reset out", {16'b0, irq_out}, 32'h0008);
      rst_n = 1'b0;
      #1 check("R1 mid reset out", {16'b0, irq_out}, 32'h0);
      qry("R1 mid reset query", 0, 8'h80);
      @(negedge clk); rst_n = 1'b1;

      // R8 slot helper
      slot_chk(8'h08, 2'd0, 2'd0);
      slot_chk(8'h08, 2'd3, 2'd3);
      slot_chk(8'h10, 2'd3, 2'd0);
      slot_chk(8'h00, 2'd0, 2'd3);
      slot_chk(8'hF8, 2'd2, 2'd0);
      slot_chk(8'h1F, 2'd1, 2'd3);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule